// File: doc/BRIEF.md
# Timestamped Edge Event Delay Line

This block delays a one-bit digital signal by an amount that can change at run time. It does not shift samples through a memory. Each change of level on the input becomes a record in a first-in first-out queue. The record holds the edge direction and the value of a free-running tick counter at the moment the edge arrived. The release side looks only at the oldest record. When enough ticks have passed since that record arrived, the output takes the record's level and the record leaves the queue.

The tick counter advances on a timebase strobe, nominally 50 kHz, so the timing resolution is one strobe period. With the default 23-bit timestamp, the longest delay is 2^23 − 1 ticks, about 167 seconds at 50 kHz. The queue depth limits only how many edges can be in transit at once. It limits neither the length of the delay nor its resolution. Because records always leave in arrival order, changing the delay needs no sorting and no search of the queue.

Top module: `edge_delay_line`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and on the first cycle after it, the output is low, the full flag is low, the overflow flag is low and the queue holds no records.
- R2: During reset the edge detector takes the current input level as its reference. An input held high through reset and afterwards therefore produces no record and no output change.
- R3: The time counter is TS_W bits wide (default 23). It increases by one on each clock with the tick strobe high, holds its value otherwise, and wraps modulo 2^TS_W.
- R4: Each input edge that arrives while the queue is not full stores one record, in arrival order. Bits TS_W-1:0 of the record hold the time counter value in the cycle the edge is seen. Bit TS_W holds the polarity: 1 for a rising edge, 0 for a falling edge.
- R5: A record is due when (now − timestamp) mod 2^TS_W ≥ delay. When the oldest record is due, it is removed, and the output takes its polarity on the same clock. The output changes no earlier than the clock after the record was stored, and never changes without a removal.
- R6: The delay input may change at any time. Records are still released strictly oldest first. A younger record is never released before an older one, even when the younger one is already due.
- R7: At most one record is removed per clock. Several records that are due at the same time leave on consecutive clocks.
- R8: The full flag is high exactly while DEPTH records are held.
- R9: An edge that arrives while the queue is full is dropped. It sets a sticky overflow flag that stays high until reset. A removal in the same cycle does not make room for that edge.
- R10: The due test gives correct results across wraparound of the time counter, for any delay up to 2^TS_W − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Timebase strobe; advances the time counter by one |
| din_i | input | 1 | Serial input to be delayed |
| delay_i | input | TS_W | Delay in ticks; may change at any time |
| dout_o | output | 1 | Delayed serial output |
| full_o | output | 1 | Queue holds DEPTH records |
| overflow_o | output | 1 | Sticky flag: an edge was dropped because the queue was full |

## Verification
The bound checker watches, on every cycle, the rules that hold at all times. These are: the output moves only on a removal, the record count stays in range and changes by the net of stores and removals, the time counter steps only on a tick, and the overflow flag is sticky and only rises when an edge meets a full queue. Other behaviour shows up only through the bench's scenarios, each compared against a queue model kept in the bench. These are: the exact release cycle for a given delay, oldest-first release while the delay changes, draining of a burst of due records one per clock, correct release across counter wraparound, and the absence of a spurious edge when the input is high through reset.

// File: rtl/edl_pkg.sv
package edl_pkg;
    // Polarity bit of a stored record.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;
endpackage

// File: rtl/edl_timebase.sv
module edl_timebase #(
    parameter int TS_W = 23
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            tick_i,
    output logic [TS_W-1:0] now_o
);
    typedef struct packed {
        logic [TS_W-1:0] now;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.now = st_q.now + 1'b1;   // wraps modulo 2^TS_W
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign now_o = st_q.now;
endmodule

// File: rtl/edl_edge_detect.sv
module edl_edge_detect
    import edl_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      din_i,
    output logic      edge_o,
    output edge_pol_e pol_o
);
    typedef struct packed {
        logic prev;
    } ed_state_t;

    ed_state_t st_d, st_q;

    always_comb begin
        st_d.prev = din_i;
    end

    // The reference level is loaded from the input during reset, so a
    // level that is already high does not count as an edge afterwards.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.prev <= din_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_o = din_i ^ st_q.prev;
    assign pol_o  = din_i ? EDGE_RISE : EDGE_FALL;
endmodule

// File: rtl/edl_event_fifo.sv
module edl_event_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 300
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       push_req_i,
    input  logic [W-1:0]               wdata_i,
    input  logic                       pop_i,
    output logic [W-1:0]               rdata_o,
    output logic                       valid_o,
    output logic                       full_o,
    output logic                       overflow_o,
    output logic                       push_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         is_full;
    logic         push_ok;
    logic         pop_ok;

    assign is_full = (st_q.cnt == CAP);
    assign push_ok = push_req_i & ~is_full;   // a same-cycle pop frees no room
    assign pop_ok  = pop_i & (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (push_req_i && is_full) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_ok) begin
            mem_q[st_q.wr] <= wdata_i;
        end
    end

    assign rdata_o    = mem_q[st_q.rd];
    assign valid_o    = (st_q.cnt != '0);
    assign full_o     = is_full;
    assign overflow_o = st_q.ovf;
    assign push_o     = push_ok;
    assign count_o    = st_q.cnt;
endmodule

// File: rtl/edl_release.sv
module edl_release #(
    parameter int TS_W = 23
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [TS_W-1:0] now_i,
    input  logic [TS_W:0]   head_i,
    input  logic            head_valid_i,
    input  logic [TS_W-1:0] delay_i,
    output logic            pop_o,
    output logic            dout_o
);
    typedef struct packed {
        logic dout;
    } rel_state_t;

    rel_state_t      st_d, st_q;
    logic [TS_W-1:0] elapsed;
    logic            due;

    // Modular difference: correct across counter wraparound.
    assign elapsed = now_i - head_i[TS_W-1:0];
    assign due     = head_valid_i && (elapsed >= delay_i);

    always_comb begin
        st_d = st_q;
        if (due) begin
            st_d.dout = head_i[TS_W];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pop_o  = due;
    assign dout_o = st_q.dout;
endmodule

// File: rtl/edge_delay_line.sv
module edge_delay_line
    import edl_pkg::*;
#(
    parameter int TS_W  = 23,
    parameter int DEPTH = 300
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            tick_i,
    input  logic            din_i,
    input  logic [TS_W-1:0] delay_i,
    output logic            dout_o,
    output logic            full_o,
    output logic            overflow_o
);
    localparam int REC_W = TS_W + 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [TS_W-1:0]  now_w;
    logic             edge_w;
    edge_pol_e        pol_w;
    logic [REC_W-1:0] rec_in;
    logic [REC_W-1:0] head_w;
    logic             head_valid;
    logic             pop_w;
    logic             push_w;
    logic [CW-1:0]    count_w;

    edl_timebase #(.TS_W(TS_W)) u_time (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick_i),
        .now_o  (now_w)
    );

    edl_edge_detect u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .din_i  (din_i),
        .edge_o (edge_w),
        .pol_o  (pol_w)
    );

    assign rec_in = {pol_w, now_w};

    edl_event_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .push_req_i (edge_w),
        .wdata_i    (rec_in),
        .pop_i      (pop_w),
        .rdata_o    (head_w),
        .valid_o    (head_valid),
        .full_o     (full_o),
        .overflow_o (overflow_o),
        .push_o     (push_w),
        .count_o    (count_w)
    );

    edl_release #(.TS_W(TS_W)) u_rel (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .now_i        (now_w),
        .head_i       (head_w),
        .head_valid_i (head_valid),
        .delay_i      (delay_i),
        .pop_o        (pop_w),
        .dout_o       (dout_o)
    );
endmodule

module edl_checker #(
    parameter int TS_W  = 23,
    parameter int DEPTH = 300
) (
    input logic                       clk_i,
    input logic                       rst_i,
    input logic                       tick_i,
    input logic                       dout_o,
    input logic                       full_o,
    input logic                       overflow_o,
    input logic [TS_W-1:0]            now_w,
    input logic                       pop_w,
    input logic                       push_w,
    input logic [$clog2(DEPTH+1)-1:0] count_w
);
    localparam int CW = $clog2(DEPTH + 1);

    a_r5_dout_moves_on_release: assert property (@(posedge clk_i) disable iff (rst_i)
        (dout_o != $past(dout_o)) |-> $past(pop_w));

    a_r3_time_steps_on_tick: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_i |=> (now_w == $past(now_w) + 1'b1));

    a_r3_time_holds_without_tick: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(now_w));

    a_r8_count_bounded: assert property (@(posedge clk_i) disable iff (rst_i)
        count_w <= CW'(DEPTH));

    a_r8_full_only_at_capacity: assert property (@(posedge clk_i) disable iff (rst_i)
        full_o |-> (count_w == CW'(DEPTH)));

    a_r4_store_grows_queue: assert property (@(posedge clk_i) disable iff (rst_i)
        (push_w && !pop_w) |=> (count_w == $past(count_w) + 1'b1));

    a_r7_single_release_shrinks_by_one: assert property (@(posedge clk_i) disable iff (rst_i)
        (pop_w && !push_w) |=> (count_w == $past(count_w) - 1'b1));

    a_r9_overflow_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        overflow_o |=> overflow_o);

    a_r9_overflow_needs_full: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(overflow_o) |-> $past(full_o));
endmodule

bind edge_delay_line edl_checker #(.TS_W(TS_W), .DEPTH(DEPTH)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (tick_i),
    .dout_o     (dout_o),
    .full_o     (full_o),
    .overflow_o (overflow_o),
    .now_w      (now_w),
    .pop_w      (pop_w),
    .push_w     (push_w),
    .count_w    (count_w)
);

// File: tb/tb_edge_delay_line.sv
module tb_edge_delay_line;
    localparam int TSW   = 8;
    localparam int DEPTH = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tick = 1'b0;
    logic           din = 1'b0;
    logic [TSW-1:0] delay = '0;
    logic           dout, full, ovf;

    int checks = 0;
    int fails  = 0;
    bit compare_on = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;   // 200 MHz

    edge_delay_line #(.TS_W(TSW), .DEPTH(DEPTH)) dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .tick_i     (tick),
        .din_i      (din),
        .delay_i    (delay),
        .dout_o     (dout),
        .full_o     (full),
        .overflow_o (ovf)
    );

    // ---------------- reference queue model ----------------
    logic [TSW-1:0] m_ts  [64];
    logic           m_pol [64];
    int             m_hd, m_cnt;
    logic [TSW-1:0] m_now;
    logic           m_dout, m_prev, m_ovf;
    logic [TSW-1:0] m_el;
    bit             m_pop, m_push, m_wasfull;

    function automatic logic [TSW-1:0] age(input logic [TSW-1:0] n, input logic [TSW-1:0] t);
        return n - t;   // modulo 2^TSW
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_hd = 0; m_cnt = 0; m_now = '0; m_dout = 1'b0; m_prev = din; m_ovf = 1'b0;
        end else begin
            m_wasfull = (m_cnt == DEPTH);
            m_el  = age(m_now, m_ts[m_hd]);
            m_pop = (m_cnt > 0) && (m_el >= delay);
            m_push = (din != m_prev);
            if (m_push && m_wasfull) m_ovf = 1'b1;
            if (m_push && !m_wasfull) begin
                m_ts[(m_hd + m_cnt) % 64]  = m_now;
                m_pol[(m_hd + m_cnt) % 64] = din;
                m_cnt = m_cnt + 1;
            end
            if (m_pop) begin
                m_dout = m_pol[m_hd];
                m_hd   = (m_hd + 1) % 64;
                m_cnt  = m_cnt - 1;
            end
            m_prev = din;
            if (tick) m_now = m_now + 1'b1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on && !rst) begin
            check(tag, "dout", dout, m_dout);
            check(tag, "full (R8)", full, (m_cnt == DEPTH));
            check(tag, "overflow (R9)", ovf, m_ovf);
        end
    end

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst = 1'b1; din = lvl; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;   // 200,000 cycles
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        do_reset(1'b0);
        check("R1", "dout after reset", dout, 0);
        check("R1", "full after reset", full, 0);
        check("R1", "overflow after reset", ovf, 0);

        // R5 directed: delay 4 with a tick every cycle
        delay = 8'd4; tick = 1'b1;
        repeat (2) @(negedge clk);
        din = 1'b1;
        repeat (4) @(negedge clk);
        check("R5", "dout one cycle before due", dout, 0);
        @(negedge clk);
        check("R5", "dout when due", dout, 1);
        // R5 delay 0: output follows on the second clock
        delay = '0;
        repeat (2) @(negedge clk);
        din = 1'b0;
        @(negedge clk);
        check("R5", "dout stored only", dout, 1);
        @(negedge clk);
        check("R5", "dout delay zero", dout, 0);

        // R2: input high through reset makes no edge
        do_reset(1'b1);
        tick = 1'b1; delay = '0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R2", "dout primed", dout, 0);
            check("R2", "full primed", full, 0);
        end

        // R9 / R7: freeze time, overfill, then drain
        do_reset(1'b0);
        compare_on = 1'b1;
        tag = "R9";
        tick = 1'b0; delay = 8'hFF;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            din = ~din;
        end
        @(negedge clk);
        check("R8", "full after fill", full, 1);
        check("R9", "overflow after drop", ovf, 1);
        tag = "R7";
        delay = '0;
        for (int i = 0; i < DEPTH; i++) @(negedge clk);
        check("R7", "drained one per cycle", full, 0);
        repeat (3) @(negedge clk);
        check("R9", "overflow sticky", ovf, 1);

        // R7: burst that falls due together
        do_reset(1'b0);
        tag = "R7";
        tick = 1'b1; delay = 8'd20;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            din = ~din;
        end
        repeat (30) @(negedge clk);

        // R10: long delay across counter wraparound
        do_reset(1'b0);
        tag = "R10";
        tick = 1'b1; delay = 8'd200;
        for (int i = 0; i < 900; i++) begin
            @(negedge clk);
            if (i % 70 == 5) din = ~din;
        end
        delay = 8'd255;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (i % 90 == 3) din = ~din;
        end

        // R6 / R3 / R4: random delay changes, sparse ticks, random edges
        do_reset(1'b0);
        tag = "R6";
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            tick = ($urandom % 10) < 7;
            if ($urandom % 8 == 0) din = ~din;
            if ($urandom % 40 == 0) delay = TSW'($urandom % 61);
            if (i % 5000 == 4999) begin
                tag = "R4";
            end
        end
        // boundary: maximum delay
        tag = "R10";
        delay = 8'hFF; tick = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i == 10 || i == 300) din = ~din;
        end
        compare_on = 1'b0;
        finish_run();
    end
endmodule